// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block is a small bank of supervisor-written control registers. Each register that can be written is guarded by a lock. The bank sits behind a plain synchronous bus slave port: one write strobe, one read strobe, a shared address, a write word and a registered read word. The top byte of every guarded register is a key field. Writing the open code there unlocks the register, writing the close code locks it again, and writing zero leaves the lock state alone. The payload bits take a write only while the register is open. A single write can carry a new payload together with the close code, so the value changes and the lock is restored on the same edge.

Three kinds of fault drive one shared alarm, one clock after they happen: a payload write to a locked register, a key byte that is neither zero nor a valid code, and a parity mismatch on a parity-guarded register. Parity is checked on every cycle. The alarm also sets a sticky status bit. That bit sits in a read-only status word and is cleared through a command word. The command word reads as zero, and every value written to it appears on a one-cycle command output.

Address map (N = number of guarded registers): guarded registers at 0..N-1, the status word at N, the command word at N+1. All other addresses are unmapped.

Top module: `kreg_bank`

## Requirements
- R1: After reset, every guarded register is locked. Register i holds RST_SEED[22:0] XOR i with its parity bit consistent with that value. The alarm output is 0 and the sticky status bit is 0.
- R2: A read returns its word on rdata in the cycle after rd_en, and 0 when rd_en is low. For a guarded register the word is {8'h00, open bit at bit 23, payload in bits 22:0}. The key byte always reads 0, and bit 23 of a write never changes the open bit.
- R3: A write with key byte 8'h00 to a locked register leaves its payload unchanged and raises the alarm.
- R4: A write with key byte UNLOCK (8'hA5) opens a locked register without changing its payload and without an alarm.
- R5: On an open register, a write with key 8'h00 or UNLOCK stores bits 22:0 and keeps the register open. A write with key LOCK (8'h5A) stores bits 22:0 and locks the register on the same edge.
- R6: A write with key LOCK to a locked register changes nothing and raises no alarm.
- R7: A write whose key byte is nonzero and neither UNLOCK nor LOCK changes neither payload nor lock state, whatever the state, and raises the alarm.
- R8: On each register selected by PAR_MASK, a mismatch between the stored payload and its parity bit raises the alarm in every cycle it persists. A mismatch on a register not selected raises nothing.
- R9: The alarm is a registered pulse, high for the cycle after each faulting cycle. Every such event sets the sticky bit, bit 0 of the status word. Writing a word with bit 0 set to the command word clears it, and a fault in the same cycle wins.
- R10: Writes to the status word are accepted without alarm and leave it unchanged.
- R11: A write to the command word drives the written value on cmd_pulse for exactly the next cycle, with 0 otherwise. The command word reads as 0.
- R12: Unmapped addresses read as 0, and writes to them change nothing and raise no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address for read or write |
| wdata | input | DATA_W | Write word |
| rdata | output | DATA_W | Registered read word |
| alarm | output | 1 | One-cycle fault pulse |
| cmd_pulse | output | DATA_W | Command word, valid for one cycle |

## Verification
The bench uses the default parameters: four guarded registers, codes 8'hA5 and 8'h5A, a 4-bit address, and PAR_MASK = 4'b1011. With that mask, registers 0 and 2 show both sides of R8: a parity bit forced wrong on register 0 must raise the alarm in every cycle it stays wrong, and the same fault on register 2 must raise nothing. The 4-bit address leaves addresses 6 to 15 unmapped for R12. The default seed gives every register a distinct nonzero reset payload, so a write that should have been ignored shows up as a changed value.

// File: rtl/kreg_pkg.sv
package kreg_pkg;

    // What a write does to the lock of the addressed slot
    typedef enum logic [1:0] {
        KEY_NONE  = 2'd0,
        KEY_OPEN  = 2'd1,
        KEY_CLOSE = 2'd2,
        KEY_BAD   = 2'd3
    } key_e;

    // Fault sources collected for the alarm stage
    typedef struct packed {
        logic wfault;
        logic perr;
    } fault_t;

    function automatic key_e classify_key(input logic [7:0] k,
                                          input logic [7:0] open_code,
                                          input logic [7:0] close_code);
        if (k == 8'h00)            return KEY_NONE;
        else if (k == open_code)   return KEY_OPEN;
        else if (k == close_code)  return KEY_CLOSE;
        else                       return KEY_BAD;
    endfunction

endpackage

// File: rtl/kreg_slot.sv
module kreg_slot
    import kreg_pkg::*;
#(
    parameter int             PAY_W   = 23,
    parameter logic [PAY_W-1:0] RST_VAL = '0,
    parameter bit             PAR_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  key_e             key,
    input  logic [PAY_W-1:0] wpay,
    output logic [PAY_W-1:0] pay,
    output logic             open,
    output logic             fault,
    output logic             perr
);

    logic [PAY_W-1:0] pay_q;
    logic             par_q;
    logic             open_q;
    logic             take;

    // Payload follows the lock state that held before this write
    assign take = sel && open_q && (key != KEY_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q  <= RST_VAL;
            par_q  <= ^RST_VAL;
            open_q <= 1'b0;
        end else begin
            if (take) begin
                pay_q <= wpay;
                par_q <= ^wpay;
            end
            if (sel) begin
                case (key)
                    KEY_OPEN:  open_q <= 1'b1;
                    KEY_CLOSE: open_q <= 1'b0;
                    default:   ;
                endcase
            end
        end
    end

    assign fault = sel && ((key == KEY_BAD) || (key == KEY_NONE && !open_q));

    generate
        if (PAR_EN) begin : g_par
            assign perr = par_q ^ (^pay_q);
        end else begin : g_nopar
            assign perr = 1'b0;
        end
    endgenerate

    assign pay  = pay_q;
    assign open = open_q;

endmodule

// File: rtl/kreg_decode.sv
module kreg_decode
    import kreg_pkg::*;
#(
    parameter int         N_REGS = 4,
    parameter int         ADDR_W = 4,
    parameter logic [7:0] UNLOCK = 8'hA5,
    parameter logic [7:0] LOCK   = 8'h5A
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        key_byte,
    output logic [N_REGS-1:0] sel,
    output key_e              key,
    output logic              cmd_wr
);

    localparam int CMD_ADDR = N_REGS + 1;

    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_sel
            assign sel[i] = wr_en && (addr == ADDR_W'(i));
        end
    endgenerate

    assign key    = classify_key(key_byte, UNLOCK, LOCK);
    assign cmd_wr = wr_en && (addr == ADDR_W'(CMD_ADDR));

endmodule

// File: rtl/kreg_alarm.sv
module kreg_alarm
    import kreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  fault_t            src,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              alarm,
    output logic              sticky,
    output logic [DATA_W-1:0] cmd_pulse
);

    logic              evt;
    logic              alarm_q;
    logic              sticky_q;
    logic [DATA_W-1:0] cmd_q;

    assign evt = src.wfault | src.perr;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= 1'b0;
            sticky_q <= 1'b0;
            cmd_q    <= '0;
        end else begin
            alarm_q <= evt;
            if (evt)
                sticky_q <= 1'b1;
            else if (cmd_wr && cmd_data[0])
                sticky_q <= 1'b0;
            cmd_q <= cmd_wr ? cmd_data : '0;
        end
    end

    assign alarm     = alarm_q;
    assign sticky    = sticky_q;
    assign cmd_pulse = cmd_q;

endmodule

// File: rtl/kreg_bank.sv
module kreg_bank
    import kreg_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 4,
    parameter int                N_REGS   = 4,
    parameter logic [7:0]        UNLOCK   = 8'hA5,
    parameter logic [7:0]        LOCK     = 8'h5A,
    parameter logic [N_REGS-1:0] PAR_MASK = N_REGS'('b1011),
    parameter logic [DATA_W-1:0] RST_SEED = 32'h0012_3400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm,
    output logic [DATA_W-1:0] cmd_pulse
);

    localparam int PAY_W     = DATA_W - 9;
    localparam int STAT_ADDR = N_REGS;

    logic [N_REGS-1:0]            sel;
    key_e                         key;
    logic                         cmd_wr;
    logic [N_REGS-1:0][PAY_W-1:0] pay_w;
    logic [N_REGS-1:0]            open_w;
    logic [N_REGS-1:0]            fault_w;
    logic [N_REGS-1:0]            perr_w;
    logic                         perr_any;
    logic                         sticky;
    fault_t                       src;
    logic [DATA_W-1:0]            rd_word;
    logic [DATA_W-1:0]            rdata_q;

    kreg_decode #(
        .N_REGS (N_REGS),
        .ADDR_W (ADDR_W),
        .UNLOCK (UNLOCK),
        .LOCK   (LOCK)
    ) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .key_byte (wdata[DATA_W-1 -: 8]),
        .sel      (sel),
        .key      (key),
        .cmd_wr   (cmd_wr)
    );

    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_slot
            kreg_slot #(
                .PAY_W   (PAY_W),
                .RST_VAL (RST_SEED[PAY_W-1:0] ^ PAY_W'(i)),
                .PAR_EN  (PAR_MASK[i])
            ) u_slot (
                .clk   (clk),
                .rst   (rst),
                .sel   (sel[i]),
                .key   (key),
                .wpay  (wdata[PAY_W-1:0]),
                .pay   (pay_w[i]),
                .open  (open_w[i]),
                .fault (fault_w[i]),
                .perr  (perr_w[i])
            );
        end
    endgenerate

    assign perr_any   = |perr_w;
    assign src.wfault = |fault_w;
    assign src.perr   = perr_any;

    kreg_alarm #(
        .DATA_W (DATA_W)
    ) u_alarm (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .cmd_wr    (cmd_wr),
        .cmd_data  (wdata),
        .alarm     (alarm),
        .sticky    (sticky),
        .cmd_pulse (cmd_pulse)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (addr == ADDR_W'(i))
                rd_word = {8'h00, open_w[i], pay_w[i]};
        end
        if (addr == ADDR_W'(STAT_ADDR))
            rd_word = DATA_W'(sticky);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else
            rdata_q <= rd_en ? rd_word : '0;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/kreg_bank_chk.sv
module kreg_bank_chk #(
    parameter int         DATA_W = 32,
    parameter int         ADDR_W = 4,
    parameter int         N_REGS = 4,
    parameter int         PAY_W  = 23,
    parameter logic [7:0] UNLOCK = 8'hA5,
    parameter logic [7:0] LOCK   = 8'h5A
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic [DATA_W-1:0]            rdata,
    input logic                         alarm,
    input logic [DATA_W-1:0]            cmd_pulse,
    input logic [N_REGS-1:0]            open_w,
    input logic [N_REGS-1:0][PAY_W-1:0] pay_w,
    input logic                         perr_any,
    input logic                         sticky
);

    localparam int CMD_ADDR = N_REGS + 1;

    logic [7:0] kb;
    logic       bad_key;
    logic       prot_hit;

    assign kb       = wdata[DATA_W-1 -: 8];
    assign bad_key  = (kb != 8'h00) && (kb != UNLOCK) && (kb != LOCK);
    assign prot_hit = int'(addr) < N_REGS;

    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_chk
            assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
                !open_w[i] |=> $stable(pay_w[i]));

            assert_denied_alarm_R3: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr == ADDR_W'(i) && kb == 8'h00 && !open_w[i]) |=> alarm);

            assert_close_locks_R5: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr == ADDR_W'(i) && kb == LOCK) |=> !open_w[i]);
        end
    endgenerate

    assert_bad_key_alarm_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prot_hit && bad_key) |=> alarm);

    assert_parity_alarm_R8: assert property (@(posedge clk) disable iff (rst)
        perr_any |=> alarm);

    assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        alarm |-> sticky);

    assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rdata[DATA_W-1 -: 8] == 8'h00));

    assert_cmd_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_W'(CMD_ADDR)) |=> (cmd_pulse == '0));

endmodule

bind kreg_bank kreg_bank_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_REGS (N_REGS),
    .PAY_W  (PAY_W),
    .UNLOCK (UNLOCK),
    .LOCK   (LOCK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .alarm     (alarm),
    .cmd_pulse (cmd_pulse),
    .open_w    (open_w),
    .pay_w     (pay_w),
    .perr_any  (perr_any),
    .sticky    (sticky)
);

// File: tb/test_kreg_bank.sv
module test_kreg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        alarm;
    logic [31:0] cmd_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    logic [22:0] exp_pay  [NR];
    logic        exp_open [NR];
    logic        last_alarm;
    logic [31:0] last_cmd;
    logic [31:0] next_cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    kreg_bank i_kreg_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .alarm     (alarm),
        .cmd_pulse (cmd_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        last_alarm = alarm;
        last_cmd   = cmd_pulse;
        @(negedge clk);
        next_cmd = cmd_pulse;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] slot_word(input int i);
        return {8'h00, exp_open[i], exp_pay[i]};
    endfunction

    task automatic check_slot(input string req, input int i);
        logic [31:0] d;
        bus_read(4'(i), d);
        check(req, d, slot_word(i));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int i = 0; i < NR; i++) begin
            exp_pay[i]  = 23'h123400 ^ 23'(i);
            exp_open[i] = 1'b0;
        end
        check("R1 alarm after reset", 32'(alarm), 32'h0);
        for (int i = 0; i < NR; i++) check_slot("R1/R2 reset word", i);
        bus_read(4'd4, d);
        check("R1 sticky after reset", d, 32'h0);
        check("R2 idle rdata", rdata, 32'h0);
    endtask

    task automatic t_locked_write;
        bus_write(4'd1, 32'h0000_0FFF);
        check("R3 denied write alarm", 32'(last_alarm), 32'h1);
        check("R9 alarm single cycle", 32'(alarm), 32'h0);
        check_slot("R3 locked payload kept", 1);
    endtask

    task automatic t_unlock_update;
        bus_write(4'd1, 32'hA500_0000);
        exp_open[1] = 1'b1;
        check("R4 unlock no alarm", 32'(last_alarm), 32'h0);
        check_slot("R4 unlock keeps payload", 1);
        bus_write(4'd1, 32'h00FF_FFFF);
        exp_pay[1] = 23'h7FFFFF;
        check("R5 open write no alarm", 32'(last_alarm), 32'h0);
        check_slot("R5 open write stored, bit 23 ignored", 1);
        bus_write(4'd1, 32'hA500_1234);
        exp_pay[1] = 23'h001234;
        check_slot("R5 write with open code stored", 1);
        bus_write(4'd1, 32'h5A80_0001);
        exp_pay[1]  = 23'h000001;
        exp_open[1] = 1'b0;
        check("R5 combined relock no alarm", 32'(last_alarm), 32'h0);
        check_slot("R5/R2 combined update and relock", 1);
    endtask

    task automatic t_three_writes;
        bus_write(4'd3, 32'hA500_0000);
        exp_open[3] = 1'b1;
        bus_write(4'd3, 32'h0055_AA55);
        exp_pay[3] = 23'h55AA55;
        check_slot("R5 second write stored", 3);
        bus_write(4'd3, 32'h5A55_AA55);
        exp_open[3] = 1'b0;
        check_slot("R5 third write relocks", 3);
        bus_write(4'd3, 32'h0000_0000);
        check("R3 relocked register denies", 32'(last_alarm), 32'h1);
        check_slot("R3 relocked payload kept", 3);
    endtask

    task automatic t_lock_when_locked;
        bus_write(4'd0, 32'h5A00_0055);
        check("R6 close on locked no alarm", 32'(last_alarm), 32'h0);
        check_slot("R6 close on locked no change", 0);
    endtask

    task automatic t_bad_key;
        bus_write(4'd0, 32'h3300_0000);
        check("R7 bad key locked alarm", 32'(last_alarm), 32'h1);
        check_slot("R7 bad key locked no change", 0);
        bus_write(4'd0, 32'hA500_0000);
        exp_open[0] = 1'b1;
        bus_write(4'd0, 32'hFF00_1234);
        check("R7 bad key open alarm", 32'(last_alarm), 32'h1);
        check_slot("R7 bad key open no change", 0);
        bus_write(4'd0, 32'h5A00_0000 | 32'(exp_pay[0]));
        exp_open[0] = 1'b0;
        check_slot("R5 relock after bad key", 0);
    endtask

    task automatic t_parity;
        logic p0;
        logic p2;
        p0 = ^exp_pay[0];
        p2 = ^exp_pay[2];
        @(negedge clk);
        check("R8 alarm quiet before fault", 32'(alarm), 32'h0);
        force i_kreg_bank.g_slot[0].u_slot.par_q = ~p0;
        @(negedge clk);
        check("R8 parity fault alarm", 32'(alarm), 32'h1);
        @(negedge clk);
        check("R8 parity fault persists", 32'(alarm), 32'h1);
        force i_kreg_bank.g_slot[0].u_slot.par_q = p0;
        @(negedge clk);
        check("R8 alarm stops when repaired", 32'(alarm), 32'h0);
        release i_kreg_bank.g_slot[0].u_slot.par_q;
        force i_kreg_bank.g_slot[2].u_slot.par_q = ~p2;
        @(negedge clk);
        check("R8 unguarded slot no alarm", 32'(alarm), 32'h0);
        @(negedge clk);
        check("R8 unguarded slot still quiet", 32'(alarm), 32'h0);
        force i_kreg_bank.g_slot[2].u_slot.par_q = p2;
        @(negedge clk);
        release i_kreg_bank.g_slot[2].u_slot.par_q;
        check_slot("R8 payload untouched by fault", 0);
    endtask

    task automatic t_status_cmd;
        logic [31:0] d;
        bus_read(4'd4, d);
        check("R9 sticky set", d, 32'h1);
        bus_write(4'd4, 32'h0000_0000);
        check("R10 status write no alarm", 32'(last_alarm), 32'h0);
        bus_read(4'd4, d);
        check("R10 status write ignored", d, 32'h1);
        bus_write(4'd5, 32'h0000_0002);
        check("R11 cmd pulse value", last_cmd, 32'h0000_0002);
        check("R11 cmd pulse one cycle", next_cmd, 32'h0);
        bus_read(4'd4, d);
        check("R9 bit0 clear needed", d, 32'h1);
        bus_write(4'd5, 32'hDEAD_BEE1);
        check("R11 cmd pulse value 2", last_cmd, 32'hDEAD_BEE1);
        check("R11 cmd no alarm", 32'(last_alarm), 32'h0);
        bus_read(4'd4, d);
        check("R9 sticky cleared", d, 32'h0);
        bus_read(4'd5, d);
        check("R11 cmd reads zero", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_write(4'd9, 32'hA5FF_FFFF);
        check("R12 unmapped write no alarm", 32'(last_alarm), 32'h0);
        check("R12 unmapped write no cmd", last_cmd, 32'h0);
        bus_read(4'd9, d);
        check("R12 unmapped reads zero", d, 32'h0);
        for (int i = 0; i < NR; i++) check_slot("R12 slots untouched", i);
        bus_read(4'd4, d);
        check("R12 sticky untouched", d, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked_write();
        t_unlock_update();
        t_three_writes();
        t_lock_when_locked();
        t_bad_key();
        t_parity();
        t_status_cmd();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule